// File: doc/BRIEF.md
# I2C Master Serial-Clock Rate Generator

This block turns the system clock into the serial-clock timing of an I2C master. A 4-bit mode word carries three fields and an enable. A 2-bit select picks a power-of-two predivider. A 1-bit filter flag lengthens the linear divider stage. A separate 8-bit divider value sets the linear divider. While enabled, the block emits a one-cycle half-period tick for a bit-level engine and drives a free-running serial-clock level that toggles on every tick. While disabled, the block idles high and keeps its counter cleared.

A companion rate search helps software choose settings. It takes a system-clock frequency and a requested bus rate, and it uses the filter flag from the mode word. It then tries the four predivider settings one per cycle. For each setting it derives the divider value and the rate that value would give. It returns the setting whose rate is closest to the request without exceeding it.

Top module: `scl_clk_divider`

## Requirements
- R1: Out of reset, `scl_o` is 1, `tick_o` is 0 and `srch_done` is 0.
- R2: While the enable bit is 0, `scl_o` stays 1, `tick_o` stays 0 and the half-period counter is held at zero, so the first tick after enabling comes one full half-period after the first enabled clock edge.
- R3: The predivider factor P is 32 shifted right by the select field: select 0,1,2,3 gives 32,16,8,4.
- R4: While enabled, `tick_o` pulses for one cycle every P × (D + 3 + 2 × F) system clocks, where D is `div_val` and F is the filter bit, and `scl_o` inverts on each tick, so one serial-clock period is twice that count.
- R5: Setting the filter bit adds 2 to the linear divider term of R4.
- R6: The mode word `mode_reg` holds the enable at bit 0, the predivider select at bits 2:1 and the filter at bit 3.
- R7: For a search with system clock H, rate S and filter F, the candidate divider for predivider P is floor((ceil(H / (P × S)) + 1) / 2) − 3 − 2F. A candidate below 0 or above 255, or a case with P × S equal to 0, is invalid. A valid candidate gives the rate floor(H / (2P × (candidate + 3 + 2F))).
- R8: The search keeps the setting whose valid rate R satisfies R ≤ S and S − R < the best difference so far. The best difference starts at S, and settings are tried in select order 0 to 3, so a tie keeps the earlier select. `srch_found` is 1 only if some setting was kept. Otherwise `srch_sel` and `srch_div` are 0.
- R9: A request sampled while idle raises `srch_done` for exactly one cycle, four clock edges after the edge that sampled it, with results valid in that cycle and held afterwards. A request that arrives while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_reg | input | 4 | Mode word: bit 0 enable, bits 2:1 predivider select, bit 3 filter |
| div_val | input | DIV_W | Linear divider value D |
| scl_o | output | 1 | Serial-clock level, idles high |
| tick_o | output | 1 | One-cycle half-period tick |
| srch_req | input | 1 | Start a rate search |
| srch_sysclk | input | HZ_W | System clock frequency in Hz |
| srch_rate | input | HZ_W | Requested bus rate in Hz |
| srch_done | output | 1 | One-cycle search completion pulse |
| srch_found | output | 1 | A valid setting was chosen |
| srch_sel | output | 2 | Chosen predivider select |
| srch_div | output | DIV_W | Chosen divider value |

## Verification
When the enable is set in a given cycle, the first tick is registered on the N-th following edge, where N is the R4 count. Every later tick comes N edges after the previous one. The scoreboard counts the edges the enable was seen on and compares that count with N when a tick appears. Search results are due four edges after the sampling edge, which is five edges after the request is driven. The monitor checks that latency against the cycle stamp the driver stored, together with the returned fields. All outputs are read on the falling edge, away from the edge that updates them.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
   // Mode word layout: filter at bit 3, select at bits 2:1, enable at bit 0.
   typedef struct packed {
      logic       filt;
      logic [1:0] sel;
      logic       en;
   } scl_mode_t;

   localparam int unsigned MODE_W = $bits(scl_mode_t);
   localparam int unsigned SEL_W  = 2;
   localparam int unsigned NUM_SEL = 1 << SEL_W;
endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned PRE_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       sel,
   input  logic             filt,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic             scl
);
   localparam int unsigned CNT_W = PRE_LOG2 + DIV_W + 2;

   logic [CNT_W-1:0] pre_w;
   logic [CNT_W-1:0] term_w;
   logic [CNT_W-1:0] half_w;
   logic [CNT_W-1:0] cnt_q;
   logic             tick_q;
   logic             scl_q;

   // Half-period length in system clocks.
   always_comb begin
      pre_w  = CNT_W'(1) << (CNT_W'(PRE_LOG2) - CNT_W'(sel));
      term_w = CNT_W'(div) + CNT_W'(3) + (filt ? CNT_W'(2) : CNT_W'(0));
      half_w = pre_w * term_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
         scl_q  <= 1'b1;
      end else if (!en) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
         scl_q  <= 1'b1;
      end else if (cnt_q >= half_w - CNT_W'(1)) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
         scl_q  <= ~scl_q;
      end else begin
         cnt_q  <= cnt_q + CNT_W'(1);
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;
   assign scl  = scl_q;

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (scl && !tick));

   assert_toggle_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (scl != $past(scl)));

   assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && $past(en)) |-> $stable(scl));
endmodule

// File: rtl/scl_cand_eval.sv
module scl_cand_eval #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned PRE_LOG2 = 5,
   parameter int unsigned HZ_W     = 32
) (
   input  logic [HZ_W-1:0]  hz,
   input  logic [HZ_W-1:0]  rate,
   input  logic [1:0]       sel,
   input  logic             filt,
   output logic             valid,
   output logic [DIV_W-1:0] cand,
   output logic [HZ_W-1:0]  tot
);
   localparam int unsigned AW = HZ_W + PRE_LOG2 + 3;
   localparam logic [AW:0] DIV_MAX = (AW+1)'((1 << DIV_W) - 1);

   logic [AW-1:0]        pre_a;
   logic [AW-1:0]        den1;
   logic [AW-1:0]        brg;
   logic [AW-1:0]        half;
   logic signed [AW:0]   cand_s;
   logic [AW-1:0]        term;
   logic [AW-1:0]        den2;
   logic [AW-1:0]        tot_a;
   logic                 den_ok;

   always_comb begin
      pre_a  = AW'(1) << (AW'(PRE_LOG2) - AW'(sel));
      den1   = pre_a * AW'(rate);
      den_ok = (den1 != '0);
      brg    = den_ok ? (AW'(hz) + den1 - AW'(1)) / den1 : '0;
      half   = (brg + AW'(1)) >> 1;
      cand_s = $signed({1'b0, half}) - $signed((AW+1)'(3))
               - (filt ? $signed((AW+1)'(2)) : $signed((AW+1)'(0)));
      valid  = den_ok && !cand_s[AW] && ($unsigned(cand_s) <= DIV_MAX);
      cand   = cand_s[DIV_W-1:0];
      term   = AW'(cand) + AW'(3) + (filt ? AW'(2) : AW'(0));
      den2   = (pre_a << 1) * term;
      tot_a  = AW'(hz) / den2;
      tot    = tot_a[HZ_W-1:0];
   end
endmodule

// File: rtl/scl_rate_search.sv
module scl_rate_search #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned PRE_LOG2 = 5,
   parameter int unsigned HZ_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [HZ_W-1:0]  hz,
   input  logic [HZ_W-1:0]  rate,
   input  logic             filt,
   output logic             done,
   output logic             found,
   output logic [1:0]       sel,
   output logic [DIV_W-1:0] div
);
   logic             busy_q;
   logic [1:0]       idx_q;
   logic [HZ_W-1:0]  hz_q;
   logic [HZ_W-1:0]  rate_q;
   logic             filt_q;
   logic [HZ_W-1:0]  best_diff_q;
   logic             found_q;
   logic [1:0]       sel_q;
   logic [DIV_W-1:0] div_q;
   logic             done_q;

   logic             c_valid;
   logic [DIV_W-1:0] c_div;
   logic [HZ_W-1:0]  c_tot;
   logic             better;

   scl_cand_eval #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2), .HZ_W(HZ_W)) u_eval (
      .hz    (hz_q),
      .rate  (rate_q),
      .sel   (idx_q),
      .filt  (filt_q),
      .valid (c_valid),
      .cand  (c_div),
      .tot   (c_tot)
   );

   // Keep a rate at or below the request that is strictly closer.
   assign better = c_valid && (c_tot <= rate_q) && ((rate_q - c_tot) < best_diff_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         idx_q       <= '0;
         hz_q        <= '0;
         rate_q      <= '0;
         filt_q      <= 1'b0;
         best_diff_q <= '0;
         found_q     <= 1'b0;
         sel_q       <= '0;
         div_q       <= '0;
         done_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req) begin
               busy_q      <= 1'b1;
               idx_q       <= '0;
               hz_q        <= hz;
               rate_q      <= rate;
               filt_q      <= filt;
               best_diff_q <= rate;
               found_q     <= 1'b0;
               sel_q       <= '0;
               div_q       <= '0;
            end
         end else begin
            if (better) begin
               best_diff_q <= rate_q - c_tot;
               found_q     <= 1'b1;
               sel_q       <= idx_q;
               div_q       <= c_div;
            end
            if (idx_q == 2'd3) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
            idx_q <= idx_q + 2'd1;
         end
      end
   end

   assign done  = done_q;
   assign found = found_q;
   assign sel   = sel_q;
   assign div   = div_q;

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy_q) && !busy_q));

   assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy_q) |=> (busy_q && idx_q == 2'd0 && !found));

   assert_empty_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (sel == 2'd0 && div == '0));
endmodule

// File: rtl/scl_clk_divider.sv
module scl_clk_divider #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned PRE_LOG2  = 5,
   parameter int unsigned HZ_W      = 32,
   parameter bit          SEARCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       mode_reg,
   input  logic [DIV_W-1:0] div_val,
   output logic             scl_o,
   output logic             tick_o,
   input  logic             srch_req,
   input  logic [HZ_W-1:0]  srch_sysclk,
   input  logic [HZ_W-1:0]  srch_rate,
   output logic             srch_done,
   output logic             srch_found,
   output logic [1:0]       srch_sel,
   output logic [DIV_W-1:0] srch_div
);
   import scl_div_pkg::*;

   scl_mode_t mode;
   assign mode = scl_mode_t'(mode_reg);

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
      $error("scl_clk_divider: DIV_W must lie in 2..16");
   end
   if (PRE_LOG2 < NUM_SEL - 1 || PRE_LOG2 > 8) begin : g_bad_pre
      $error("scl_clk_divider: PRE_LOG2 must lie in 3..8");
   end
   if (HZ_W < 8 || HZ_W > 40) begin : g_bad_hz_w
      $error("scl_clk_divider: HZ_W must lie in 8..40");
   end

   scl_tick_gen #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode.en),
      .sel   (mode.sel),
      .filt  (mode.filt),
      .div   (div_val),
      .tick  (tick_o),
      .scl   (scl_o)
   );

   if (SEARCH_EN) begin : g_search
      scl_rate_search #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2), .HZ_W(HZ_W)) u_search (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (srch_req),
         .hz    (srch_sysclk),
         .rate  (srch_rate),
         .filt  (mode.filt),
         .done  (srch_done),
         .found (srch_found),
         .sel   (srch_sel),
         .div   (srch_div)
      );
   end else begin : g_no_search
      assign srch_done  = 1'b0;
      assign srch_found = 1'b0;
      assign srch_sel   = '0;
      assign srch_div   = '0;
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (scl_o && !tick_o && !srch_done));
endmodule

// File: tb/scl_clk_divider_tb.sv
`timescale 1ns/1ps
module scl_clk_divider_tb_top;
   localparam int DIV_W = 8;
   localparam int HZ_W  = 32;
   localparam int WD_CYCLES = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       mode_reg = 4'h0;
   logic [DIV_W-1:0] div_val = '0;
   logic             scl_o, tick_o;
   logic             srch_req = 1'b0;
   logic [HZ_W-1:0]  srch_sysclk = '0;
   logic [HZ_W-1:0]  srch_rate = '0;
   logic             srch_done, srch_found;
   logic [1:0]       srch_sel;
   logic [DIV_W-1:0] srch_div;

   always #4 clk = ~clk;

   scl_clk_divider #(.DIV_W(DIV_W), .HZ_W(HZ_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .div_val(div_val),
      .scl_o(scl_o), .tick_o(tick_o), .srch_req(srch_req),
      .srch_sysclk(srch_sysclk), .srch_rate(srch_rate), .srch_done(srch_done),
      .srch_found(srch_found), .srch_sel(srch_sel), .srch_div(srch_div)
   );

   typedef struct {
      bit      found;
      int      sel;
      int      div;
      int      due;
   } srch_exp_t;

   int        exp_tick_q[$];
   srch_exp_t exp_srch_q[$];
   int        n_chk = 0;
   int        n_err = 0;
   int        cyc = 0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // R3/R4/R5: expected half-period from the fields.
   function automatic int half_len(int sel, int div, int filt);
      return (32 >> sel) * (div + 3 + 2 * filt);
   endfunction

   // R7/R8 model of the search.
   function automatic srch_exp_t model(longint hz, longint rate, int filt);
      srch_exp_t r;
      longint best;
      r.found = 0; r.sel = 0; r.div = 0; r.due = 0;
      best = rate;
      for (int s = 0; s < 4; s++) begin
         longint p = 32 >> s;
         longint d1 = p * rate;
         longint brg, c, tot;
         if (d1 == 0) continue;
         brg = (hz + d1 - 1) / d1;
         c = (brg + 1) / 2 - 3 - 2 * filt;
         if (c < 0 || c > 255) continue;
         tot = hz / (2 * p * (c + 3 + 2 * filt));
         if (tot <= rate && (rate - tot) < best) begin
            best = rate - tot; r.found = 1; r.sel = s; r.div = int'(c);
         end
      end
      return r;
   endfunction

   task automatic monitor();
      bit en_s;
      int run_cnt = 0;
      bit exp_scl = 1'b1;
      forever begin
         @(posedge clk);
         en_s = mode_reg[0];
         cyc++;
         @(negedge clk);
         if (!rst_n) continue;
         if (!en_s) begin
            run_cnt = 0;
            exp_scl = 1'b1;
         end else begin
            run_cnt++;
         end
         if (tick_o) begin
            exp_scl = ~exp_scl;
            if (exp_tick_q.size() == 0) begin
               check(0, "R4", "unexpected tick", 1, 0);
            end else begin
               int e = exp_tick_q.pop_front();
               check(run_cnt == e, "R4", "tick interval", run_cnt, e);
               check(scl_o == exp_scl, "R4", "scl level on tick", scl_o, exp_scl);
            end
            run_cnt = 0;
         end
         if (srch_done) begin
            if (exp_srch_q.size() == 0) begin
               check(0, "R9", "unexpected done", 1, 0);
            end else begin
               srch_exp_t e = exp_srch_q.pop_front();
               check(cyc == e.due, "R9", "done cycle", cyc, e.due);
               check(srch_found == e.found, "R8", "found", srch_found, e.found);
               check(srch_sel == 2'(e.sel), "R8", "select", srch_sel, e.sel);
               check(srch_div == 8'(e.div), "R7", "divider", srch_div, e.div);
            end
         end
      end
   endtask

   // Driver: run the generator with fixed fields for a number of ticks.
   task automatic run_fixed(int sel, int div, int filt, int nticks, string req);
      int n = half_len(sel, div, filt);
      for (int i = 0; i < nticks; i++) exp_tick_q.push_back(n);
      @(posedge clk); #1;
      div_val  = 8'(div);
      mode_reg = {1'(filt), 2'(sel), 1'b1};   // R6 layout
      wait (exp_tick_q.size() == 0);
      @(posedge clk); #1;
      mode_reg[0] = 1'b0;
      repeat (2) @(negedge clk);
      check(scl_o == 1'b1, "R2", {req, " scl idle after disable"}, scl_o, 1);
      check(tick_o == 1'b0, "R2", {req, " no tick when disabled"}, tick_o, 0);
   endtask

   task automatic run_search(longint hz, longint rate, int filt, bit double_req);
      srch_exp_t e = model(hz, rate, filt);
      @(posedge clk); #1;
      mode_reg[3]  = 1'(filt);
      srch_sysclk  = 32'(hz);
      srch_rate    = 32'(rate);
      srch_req     = 1'b1;
      e.due        = cyc + 5;
      exp_srch_q.push_back(e);
      if (double_req) begin
         @(posedge clk); #1;
         srch_sysclk = 32'd12_000_000;   // R9: second request while busy, ignored
         srch_rate   = 32'd400_000;
      end
      @(posedge clk); #1;
      srch_req = 1'b0;
      wait (exp_srch_q.size() == 0);
      repeat (3) @(posedge clk);
   endtask

   task automatic main_seq();
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      check(scl_o == 1'b1, "R1", "scl after reset", scl_o, 1);
      check(tick_o == 1'b0, "R1", "tick after reset", tick_o, 0);
      check(srch_done == 1'b0, "R1", "done after reset", srch_done, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R2: fields set but enable low: nothing moves for a while
      mode_reg = 4'b0110;
      div_val  = 8'd0;
      repeat (200) @(posedge clk);
      @(negedge clk);
      check(scl_o == 1'b1 && tick_o == 1'b0, "R2", "disabled with fields set", scl_o, 1);
      run_fixed(0, 0, 0, 3, "R3");
      run_fixed(3, 0, 0, 4, "R3");
      run_fixed(1, 10, 0, 3, "R4");
      run_fixed(2, 5, 1, 3, "R5");
      run_fixed(2, 5, 0, 3, "R5");
      run_fixed(3, 255, 1, 2, "R6");
      run_fixed(0, 0, 0, 2, "R2");
      run_search(100_000_000, 100_000, 0, 1'b0);
      run_search(100_000_000, 1_000, 0, 1'b0);
      run_search(50_000_000, 10_000_000, 0, 1'b0);
      run_search(100_000_000, 400_000, 1, 1'b0);
      run_search(66_000_000, 100_000, 0, 1'b1);
      run_search(100_000_000, 0, 0, 1'b0);
   endtask

   initial begin
      fork
         monitor();
      join_none
      fork
         main_seq();
         begin
            repeat (WD_CYCLES) @(posedge clk);
            check(0, "R4", "watchdog expired", cyc, WD_CYCLES);
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule